// File: doc/BRIEF.md
# Power Management Event Controller

This block holds the fixed power-management register set of a system controller and answers a simple register port. It has a free-running power-management timer, a 16-bit event status register whose bits clear when written with 1, a 16-bit event enable register and a control register that carries the SCI-enable flag and a sleep-request field. A one-cycle request on the register port either writes a 16-bit value or, through a combinational read path, returns a 32-bit word.

A separate byte port has an advanced-power-management command register and a status register. Two special command values turn SCI mode on and off. Each command write can raise a system-management interrupt. The outputs are a level SCI, a one-cycle SMI pulse and one-cycle shutdown and reset request pulses. A power-button event input sets its status bit when that event is enabled.

The timer advances on a tick-enable input that the surrounding logic asserts at 3.579545 MHz. Its width is a parameter with a default of 24 bits.

Top module: `pm_event_ctrl`

## Requirements
- R1: After the active-low synchronous reset, every register, the timer and all outputs are zero.
- R2: The timer increments by one on each clock with tick_en high and wraps at its width. A read at offset 0x08 returns it zero-extended to 32 bits.
- R3: Status bit 0 sets on each cycle in which the timer's top bit changes value. At the default width this is bit 23, so it happens on every multiple of 0x800000.
- R4: A write to status (offset 0x00) clears each bit written as 1 and keeps each bit written as 0. An event that sets a bit in the same cycle takes priority over the clear.
- R5: Enable is read and written at offset 0x02, status at 0x00 and control at 0x04, all 16 bits wide in the low half of the read word. Reads of any other offset return 0.
- R6: sci is high exactly while status AND enable AND 0x0521 is nonzero. That mask covers bits 0, 5, 8 and 10.
- R7: A control write that has bit 13 set is a sleep request. Bit 13 is never stored. When the sleep type in bits 12:10 of the same write is 0, shutdown_req pulses for one cycle in the cycle after the write.
- R8: Sleep type 1 sets status bits 15 and 8 and pulses reset_req for one cycle. Other sleep types cause no pulse, and the other control bits are stored as written.
- R9: A pwr_btn cycle sets status bit 8 only while enable bit 8 is set. Otherwise status is unchanged.
- R10: On the byte port, apm_sel=0 selects the command register and apm_sel=1 the status register. Each reads back the last byte written to it.
- R11: smi pulses for one cycle after each command write (apm_sel=0) while smi_en_cfg is high. A status write, or a command write while smi_en_cfg is low, gives no pulse.
- R12: Command 0xF1 sets control bit 0 and command 0xF0 clears it. Other commands leave it unchanged. A command write wins over a control write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer advance strobe |
| pwr_btn | input | 1 | Power-button event, one cycle |
| smi_en_cfg | input | 1 | Allows SMI on command writes |
| io_wr | input | 1 | Register port write strobe |
| io_addr | input | ADDR_W | Register byte offset |
| io_wdata | input | 16 | Register write data |
| io_rdata | output | 32 | Register read data, combinational |
| apm_wr | input | 1 | Byte port write strobe |
| apm_sel | input | 1 | 0 command, 1 status |
| apm_wdata | input | 8 | Byte port write data |
| apm_rdata | output | 8 | Byte port read data |
| sci | output | 1 | Level SCI interrupt |
| smi | output | 1 | SMI pulse |
| shutdown_req | output | 1 | Shutdown request pulse |
| reset_req | output | 1 | Reset request pulse |

## Verification
The timer's top-bit crossing and a software write that clears status bit 0 can land on the same clock edge. The bench provokes this by driving tick_en and a status write of 0x0001 in the cycle where the timer wraps from all ones to zero. Status bit 0 must still read 1 after that edge, and a later plain clear must drop it. A second collision drives a command write of 0xF1 together with a control write of zero, and control bit 0 must end up set.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
    localparam int REG_W     = 16;
    localparam int RD_W      = 32;
    localparam int OFS_STS   = 'h00;
    localparam int OFS_EN    = 'h02;
    localparam int OFS_CTL   = 'h04;
    localparam int OFS_TMR   = 'h08;
    localparam int B_TMR     = 0;
    localparam int B_PWR     = 8;
    localparam int B_WAKE    = 15;
    localparam int C_SCIEN   = 0;
    localparam int C_SLPEN   = 13;
    localparam int C_TYP_LO  = 10;
    localparam logic [REG_W-1:0] SCI_MASK = 16'h0521;
    localparam logic [7:0]       CMD_ON   = 8'hF1;
    localparam logic [7:0]       CMD_OFF  = 8'hF0;

    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] ctl;
        logic             shut;
        logic             rst;
    } pm_state_t;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] stat;
        logic       smi;
    } apm_state_t;
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [TMR_W-1:0] count,
    output logic             msb_flip
);
    localparam int MSB = TMR_W - 1;

    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_en) cnt_d = cnt_q + 1'b1;
        msb_flip = cnt_d[MSB] ^ cnt_q[MSB];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/pm_apm.sv
module pm_apm
    import pm_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       sel,
    input  logic [7:0] wdata,
    input  logic       smi_en,
    output logic [7:0] rdata,
    output logic       sci_on,
    output logic       sci_off,
    output logic       smi
);
    apm_state_t ap_d, ap_q;
    logic cmd_wr;

    always_comb begin
        ap_d     = ap_q;
        cmd_wr   = wr && !sel;
        ap_d.smi = cmd_wr && smi_en;
        if (cmd_wr)     ap_d.cmd  = wdata;
        if (wr && sel)  ap_d.stat = wdata;
        sci_on  = cmd_wr && (wdata == CMD_ON);
        sci_off = cmd_wr && (wdata == CMD_OFF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ap_q <= '0;
        else        ap_q <= ap_d;
    end

    assign rdata = sel ? ap_q.stat : ap_q.cmd;
    assign smi   = ap_q.smi;
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
    import pm_evt_pkg::*;
#(
    parameter int TMR_W  = 24,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              pwr_btn,
    input  logic              smi_en_cfg,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [REG_W-1:0]  io_wdata,
    output logic [RD_W-1:0]   io_rdata,
    input  logic              apm_wr,
    input  logic              apm_sel,
    input  logic [7:0]        apm_wdata,
    output logic [7:0]        apm_rdata,
    output logic              sci,
    output logic              smi,
    output logic              shutdown_req,
    output logic              reset_req
);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(OFS_TMR);

    pm_state_t        st_d, st_q;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_flip;
    logic             sci_on, sci_off;
    logic [REG_W-1:0] sets;
    logic [2:0]       slp_typ;

    pm_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .count    (tmr_val),
        .msb_flip (tmr_flip)
    );

    pm_apm u_apm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (apm_wr),
        .sel     (apm_sel),
        .wdata   (apm_wdata),
        .smi_en  (smi_en_cfg),
        .rdata   (apm_rdata),
        .sci_on  (sci_on),
        .sci_off (sci_off),
        .smi     (smi)
    );

    always_comb begin
        st_d      = st_q;
        st_d.shut = 1'b0;
        st_d.rst  = 1'b0;
        sets      = '0;
        slp_typ   = io_wdata[C_TYP_LO +: 3];

        if (io_wr) begin
            case (io_addr)
                A_STS: st_d.sts = st_q.sts & ~io_wdata;
                A_EN:  st_d.en  = io_wdata;
                A_CTL: begin
                    st_d.ctl          = io_wdata;
                    st_d.ctl[C_SLPEN] = 1'b0;
                    if (io_wdata[C_SLPEN]) begin
                        if (slp_typ == 3'd0) st_d.shut = 1'b1;
                        if (slp_typ == 3'd1) begin
                            st_d.rst       = 1'b1;
                            sets[B_WAKE]   = 1'b1;
                            sets[B_PWR]    = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (tmr_flip)                 sets[B_TMR] = 1'b1;
        if (pwr_btn && st_q.en[B_PWR]) sets[B_PWR] = 1'b1;
        st_d.sts = st_d.sts | sets;

        if (sci_on)  st_d.ctl[C_SCIEN] = 1'b1;
        if (sci_off) st_d.ctl[C_SCIEN] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        io_rdata = '0;
        case (io_addr)
            A_STS: io_rdata[REG_W-1:0] = st_q.sts;
            A_EN:  io_rdata[REG_W-1:0] = st_q.en;
            A_CTL: io_rdata[REG_W-1:0] = st_q.ctl;
            A_TMR: io_rdata[TMR_W-1:0] = tmr_val;
            default: ;
        endcase
    end

    assign sci          = |(st_q.sts & st_q.en & SCI_MASK);
    assign shutdown_req = st_q.shut;
    assign reset_req    = st_q.rst;
endmodule

// File: rtl/pm_event_ctrl_chk.sv
module pm_event_ctrl_chk
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic [ADDR_W-1:0] io_addr,
    input logic [REG_W-1:0]  io_wdata,
    input logic              apm_wr,
    input logic              apm_sel,
    input logic              smi_en_cfg,
    input logic              smi,
    input logic              shutdown_req,
    input logic              reset_req
);
    logic ctl_sleep, typ0, typ1, cmd_smi;
    assign ctl_sleep = io_wr && (io_addr == ADDR_W'(OFS_CTL)) && io_wdata[C_SLPEN];
    assign typ0      = ctl_sleep && (io_wdata[C_TYP_LO +: 3] == 3'd0);
    assign typ1      = ctl_sleep && (io_wdata[C_TYP_LO +: 3] == 3'd1);
    assign cmd_smi   = apm_wr && !apm_sel && smi_en_cfg;

    assert_shut_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(typ0));
    assert_shut_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        typ0 |=> shutdown_req);
    assert_rst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(typ1));
    assert_req_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(shutdown_req && reset_req));
    assert_smi_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        smi |-> $past(cmd_smi));
    assert_smi_fires_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_smi |=> smi);
endmodule

bind pm_event_ctrl pm_event_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_wr        (io_wr),
    .io_addr      (io_addr),
    .io_wdata     (io_wdata),
    .apm_wr       (apm_wr),
    .apm_sel      (apm_sel),
    .smi_en_cfg   (smi_en_cfg),
    .smi          (smi),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req)
);

// File: tb/tb_pm_event_ctrl.sv
`timescale 1ns/1ps
module tb_pm_event_ctrl;
    localparam int TW = 10;
    localparam int TMOD = 1 << TW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, pwr_btn = 1'b0, smi_en_cfg = 1'b0;
    logic        io_wr = 1'b0;
    logic [5:0]  io_addr = '0;
    logic [15:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        apm_wr = 1'b0, apm_sel = 1'b0;
    logic [7:0]  apm_wdata = '0, apm_rdata;
    logic        sci, smi, shutdown_req, reset_req;

    int n_chk = 0;
    int n_fail = 0;
    int tmr_exp = 0;

    always #2.5 clk = ~clk;

    pm_event_ctrl #(.TMR_W(TW), .ADDR_W(6)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwr_btn(pwr_btn),
        .smi_en_cfg(smi_en_cfg), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .apm_wr(apm_wr),
        .apm_sel(apm_sel), .apm_wdata(apm_wdata), .apm_rdata(apm_rdata),
        .sci(sci), .smi(smi), .shutdown_req(shutdown_req), .reset_req(reset_req)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic io_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [5:0] a, output logic [31:0] v);
        io_addr = a;
        #1;
        v = io_rdata;
    endtask

    task automatic apm_write(input logic s, input logic [7:0] d);
        @(negedge clk);
        apm_wr = 1'b1; apm_sel = s; apm_wdata = d;
        @(negedge clk);
        apm_wr = 1'b0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        tmr_exp = (tmr_exp + n) % TMOD;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        io_read(6'h00, v); check("R1 status", v, 0);
        io_read(6'h02, v); check("R1 enable", v, 0);
        io_read(6'h04, v); check("R1 control", v, 0);
        io_read(6'h08, v); check("R1 timer", v, 0);
        check("R1 outputs", {28'd0, sci, smi, shutdown_req, reset_req}, 0);
        apm_sel = 1'b0; #1; check("R1 apm cmd", apm_rdata, 0);
    endtask

    task automatic t_timer;
        logic [31:0] v;
        tick(5);
        io_read(6'h08, v); check("R2 timer count", v, tmr_exp);
        tick(100);
        io_read(6'h08, v); check("R2 timer count zero-extended", v, tmr_exp);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        tick((TMOD/2 - 1) - tmr_exp);
        io_read(6'h00, v); check("R3 no flag before top-bit change", v, 0);
        tick(1);
        io_read(6'h00, v); check("R3 flag on top-bit rise", v, 32'h1);
        io_write(6'h00, 16'h0001);
        io_read(6'h00, v); check("R4 write-1 clears", v, 0);
        tick(TMOD/2 - 1);
        io_read(6'h08, v); check("R2 timer at all ones", v, TMOD - 1);
        io_read(6'h00, v); check("R3 no flag before wrap", v, 0);
        @(negedge clk);
        tick_en = 1'b1; io_wr = 1'b1; io_addr = 6'h00; io_wdata = 16'h0001;
        @(negedge clk);
        tick_en = 1'b0; io_wr = 1'b0;
        tmr_exp = 0;
        io_read(6'h00, v); check("R4 set wins over same-cycle clear", v, 32'h1);
        io_read(6'h08, v); check("R2 timer wrapped", v, 0);
        io_write(6'h00, 16'h0000);
        io_read(6'h00, v); check("R4 write-0 keeps bit", v, 32'h1);
        io_write(6'h00, 16'hFFFF);
        io_read(6'h00, v); check("R4 clear all", v, 0);
    endtask

    task automatic t_map_sci;
        logic [31:0] v;
        io_write(6'h02, 16'hA5C3);
        io_read(6'h02, v); check("R5 enable readback", v, 32'hA5C3);
        io_read(6'h06, v); check("R5 unmapped offset", v, 0);
        io_read(6'h3C, v); check("R5 unmapped high offset", v, 0);
        io_write(6'h02, 16'h0000);
        io_write(6'h04, 16'h2400);
        check("R8 reset pulse", reset_req, 1);
        check("R8 no shutdown on type 1", shutdown_req, 0);
        io_read(6'h00, v); check("R8 status bits 15 and 8", v, 32'h8100);
        io_read(6'h04, v); check("R7 sleep-enable not stored", v, 32'h0400);
        check("R6 sci low with enable zero", sci, 0);
        io_write(6'h02, 16'h8000);
        check("R8 pulse ended", reset_req, 0);
        check("R6 bit 15 outside mask", sci, 0);
        io_write(6'h02, 16'h0100);
        check("R6 sci on bit 8", sci, 1);
        io_write(6'h00, 16'h0100);
        check("R6 sci drops on clear", sci, 0);
        io_write(6'h00, 16'h8000);
    endtask

    task automatic t_sleep;
        logic [31:0] v;
        io_write(6'h04, 16'h2000);
        check("R7 shutdown pulse", shutdown_req, 1);
        check("R7 no reset on type 0", reset_req, 0);
        @(negedge clk);
        check("R7 shutdown one cycle", shutdown_req, 0);
        io_write(6'h04, 16'h2800);
        check("R8 type 2 no pulses", {shutdown_req, reset_req}, 0);
        io_read(6'h00, v); check("R8 type 2 no status", v, 0);
        io_read(6'h04, v); check("R8 type stored", v, 32'h0800);
        io_write(6'h04, 16'h0400);
        check("R7 no sleep without bit 13", {shutdown_req, reset_req}, 0);
        io_write(6'h04, 16'h0000);
    endtask

    task automatic t_pwrbtn;
        logic [31:0] v;
        io_write(6'h02, 16'h0000);
        @(negedge clk); pwr_btn = 1'b1; @(negedge clk); pwr_btn = 1'b0;
        io_read(6'h00, v); check("R9 button ignored when disabled", v, 0);
        io_write(6'h02, 16'h0100);
        @(negedge clk); pwr_btn = 1'b1; @(negedge clk); pwr_btn = 1'b0;
        io_read(6'h00, v); check("R9 button sets bit 8", v, 32'h0100);
        check("R6 sci from button", sci, 1);
        io_write(6'h00, 16'h0100);
        io_write(6'h02, 16'h0000);
    endtask

    task automatic t_apm;
        logic [31:0] v;
        smi_en_cfg = 1'b0;
        apm_write(1'b0, 8'h3C);
        check("R11 no smi when disabled", smi, 0);
        apm_write(1'b1, 8'h5A);
        apm_sel = 1'b0; #1; check("R10 command readback", apm_rdata, 8'h3C);
        apm_sel = 1'b1; #1; check("R10 status readback", apm_rdata, 8'h5A);
        smi_en_cfg = 1'b1;
        apm_write(1'b0, 8'hF1);
        check("R11 smi pulse", smi, 1);
        io_read(6'h04, v); check("R12 F1 sets sci enable", v, 32'h1);
        @(negedge clk);
        check("R11 smi one cycle", smi, 0);
        apm_write(1'b1, 8'hF0);
        check("R11 no smi on status write", smi, 0);
        io_read(6'h04, v); check("R12 status write leaves control", v, 32'h1);
        apm_write(1'b0, 8'h77);
        io_read(6'h04, v); check("R12 other command keeps bit", v, 32'h1);
        apm_write(1'b0, 8'hF0);
        io_read(6'h04, v); check("R12 F0 clears sci enable", v, 0);
        @(negedge clk);
        apm_wr = 1'b1; apm_sel = 1'b0; apm_wdata = 8'hF1;
        io_wr = 1'b1; io_addr = 6'h04; io_wdata = 16'h0000;
        @(negedge clk);
        apm_wr = 1'b0; io_wr = 1'b0;
        io_read(6'h04, v); check("R12 command beats control write", v, 32'h1);
        smi_en_cfg = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timer();
        t_overflow();
        t_map_sci();
        t_sleep();
        t_pwrbtn();
        t_apm();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule